// File: doc/BRIEF.md
# Monitor Output Selector with Reference Clocks

This block drives four monitor output pins, each used to observe one internal or external signal on an oscilloscope or counter. Every pin has its own 6-bit selection code, held in a small write/read register file. A code picks one source from a fixed code space: the 24 per-connector multiplicity lines, four external inputs, four debug lines, five decade reference clocks, a timestamp clock, the two AND outputs, the eight multiplicity-unit outputs and the eight OR outputs of the trigger logic.

The reference clocks come from a chain of cascaded divide-by-ratio counters on the system clock. With the default ratio of 10 on a 100 MHz clock they give 10 MHz, 1 MHz, 100 kHz, 10 kHz and 1 kHz. A separate register picks which of them serves as the timestamp clock. That clock is also driven on a port of its own. The fourth external input carries a run-inhibit level, which is reported as an acquisition-stopped status.

Top module: `mon_out_sel`

## Requirements
- R1: Selection codes 0 to 23 route `mult_in[code]` to the output. Bit order is connector A1 line 0, A1 line 1, A2 line 0, and so on through C4 line 1.
- R2: Codes 24 to 27 route `ext_in[0..3]`, and codes 28 to 31 route `dbg_in[0..3]`.
- R3: Codes 32 to 36 route reference clock k = code-32. Clock k is high for the second half of each period of DIV_RATIO^(k+1) cycles, which is a 50 % duty cycle. The phase is counted in cycles since reset was released, and the clock starts low.
- R4: Code 37 routes the timestamp clock. Timestamp select values 0 to 4 pick reference clock 0 to 4, and the same clock drives `ts_clk`.
- R5: A timestamp select value of 5, 6 or 7 falls back to reference clock 0.
- R6: Codes 40 and 41 route `and_in[0..1]`, codes 48 to 55 route `unit_in[0..7]`, and codes 56 to 63 route `or_in[0..7]`.
- R7: Codes 38, 39 and 42 to 47 drive the output low.
- R8: Every monitor output, and `ts_clk`, is registered. It shows the value its source had one clock before, and each output follows only its own code.
- R9: `acq_stopped` equals `ext_in[3]` one clock later.
- R10: Address 0 to 3 holds the 6-bit code of monitor output 0 to 3. Address 4 holds the timestamp select in bits 2:0. A write takes effect on the clock edge where `wr_en` is high. `rd_data` returns the register at `rd_addr` one clock later, zero-extended. Addresses 5 to 7 read as zero, and writes to them change nothing.
- R11: Reset clears all codes and the timestamp select to 0. It drives every output low and restarts the dividers at phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 6 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 6 | Registered read data |
| mult_in | input | 24 | Per-connector multiplicity lines |
| ext_in | input | 4 | External inputs; bit 3 is run inhibit |
| dbg_in | input | 4 | Debug lines |
| and_in | input | 2 | AND trigger outputs |
| unit_in | input | 8 | Multiplicity-unit outputs |
| or_in | input | 8 | OR trigger outputs |
| mon_out | output | 4 | Monitor outputs |
| ts_clk | output | 1 | Selected timestamp clock |
| acq_stopped | output | 1 | Acquisition stopped status |

## Verification
The assertions check the following properties on every cycle:
- the one-cycle relation between the run-inhibit input and its status;
- the routing of external inputs;
- the low level for reserved codes;
- the fallback of the timestamp clock;
- the register update on writes;
- the exact run length of the first reference clock's high and low phases.

The bench's scenarios alone show the rest: the full code map across all 64 codes on every output, the periods and phases of the slower clocks, readback and the ignored addresses.

// File: rtl/mon_sel_pkg.sv
package mon_sel_pkg;
  localparam int SEL_W    = 6;
  localparam int SRC_W    = 1 << SEL_W;
  localparam int NUM_MULT = 24;
  localparam int NUM_EXT  = 4;
  localparam int NUM_DBG  = 4;
  localparam int NUM_REF  = 5;
  localparam int NUM_AND  = 2;
  localparam int NUM_UNIT = 8;
  localparam int NUM_OR   = 8;
  localparam int TS_W     = $clog2(NUM_REF);

  localparam int CODE_MULT = 0;
  localparam int CODE_EXT  = 24;
  localparam int CODE_DBG  = 28;
  localparam int CODE_REF  = 32;
  localparam int CODE_TS   = 37;
  localparam int CODE_AND  = 40;
  localparam int CODE_UNIT = 48;
  localparam int CODE_OR   = 56;

  typedef struct packed {
    logic [NUM_OR-1:0]   or_v;
    logic [NUM_UNIT-1:0] unit_v;
    logic [NUM_AND-1:0]  and_v;
    logic                ts_v;
    logic [NUM_REF-1:0]  ref_v;
    logic [NUM_DBG-1:0]  dbg_v;
    logic [NUM_EXT-1:0]  ext_v;
    logic [NUM_MULT-1:0] mult_v;
  } src_bus_t;

  // Place every source at its code; unlisted codes stay zero.
  function automatic logic [SRC_W-1:0] build_flat(input src_bus_t s);
    logic [SRC_W-1:0] f;
    f = '0;
    f[CODE_MULT +: NUM_MULT] = s.mult_v;
    f[CODE_EXT  +: NUM_EXT]  = s.ext_v;
    f[CODE_DBG  +: NUM_DBG]  = s.dbg_v;
    f[CODE_REF  +: NUM_REF]  = s.ref_v;
    f[CODE_TS]               = s.ts_v;
    f[CODE_AND  +: NUM_AND]  = s.and_v;
    f[CODE_UNIT +: NUM_UNIT] = s.unit_v;
    f[CODE_OR   +: NUM_OR]   = s.or_v;
    return f;
  endfunction
endpackage

// File: rtl/decade_div_chain.sv
module decade_div_chain #(
  parameter int RATIO      = 10,
  parameter int NUM_STAGES = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic [NUM_STAGES-1:0] clk_out
);
  localparam int CNT_W = $clog2(RATIO);
  localparam int HALF  = RATIO / 2;

  logic [NUM_STAGES-1:0] en;
  assign en[0] = 1'b1;

  genvar k;
  generate
    for (k = 0; k < NUM_STAGES; k++) begin : g_stage
      logic [CNT_W-1:0] cnt;
      logic             wrap;

      assign wrap = (cnt == CNT_W'(RATIO - 1));

      always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (en[k]) cnt <= wrap ? '0 : cnt + 1'b1;
      end

      assign clk_out[k] = (cnt >= CNT_W'(HALF));

      if (k < NUM_STAGES - 1) begin : g_link
        assign en[k+1] = en[k] & wrap;
      end
    end
  endgenerate
endmodule

// File: rtl/ts_clk_pick.sv
module ts_clk_pick #(
  parameter int NUM_REF = 5,
  parameter int TS_W    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REF-1:0] ref_clk,
  input  logic [TS_W-1:0]    ts_sel,
  output logic               ts_src,
  output logic               ts_clk
);
  // Values outside the clock list keep clock 0.
  always_comb begin
    ts_src = ref_clk[0];
    for (int k = 1; k < NUM_REF; k++) begin
      if (ts_sel == TS_W'(k)) ts_src = ref_clk[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ts_clk <= 1'b0;
    else     ts_clk <= ts_src;
  end
endmodule

// File: rtl/mon_cfg_regs.sv
module mon_cfg_regs #(
  parameter int NUM_OUT = 4,
  parameter int SEL_W   = 6,
  parameter int TS_W    = 3,
  parameter int ADDR_W  = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [SEL_W-1:0]               wr_data,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [SEL_W-1:0]               rd_data,
  output logic [NUM_OUT-1:0][SEL_W-1:0]  sel_q,
  output logic [TS_W-1:0]                ts_sel_q
);
  localparam int TS_ADDR = NUM_OUT;

  genvar g;
  generate
    for (g = 0; g < NUM_OUT; g++) begin : g_sel
      always_ff @(posedge clk) begin
        if (rst)
          sel_q[g] <= '0;
        else if (wr_en && wr_addr == ADDR_W'(g))
          sel_q[g] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      ts_sel_q <= '0;
    else if (wr_en && wr_addr == ADDR_W'(TS_ADDR))
      ts_sel_q <= wr_data[TS_W-1:0];
  end

  logic [SEL_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_OUT; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_next = sel_q[i];
    end
    if (rd_addr == ADDR_W'(TS_ADDR)) rd_next = SEL_W'(ts_sel_q);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/mon_mux_bank.sv
module mon_mux_bank #(
  parameter int NUM_OUT = 4,
  parameter int SEL_W   = 6,
  localparam int SRC_W  = 1 << SEL_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [SRC_W-1:0]              flat,
  input  logic [NUM_OUT-1:0][SEL_W-1:0] sel,
  output logic [NUM_OUT-1:0]            mon_q
);
  genvar g;
  generate
    for (g = 0; g < NUM_OUT; g++) begin : g_out
      always_ff @(posedge clk) begin
        if (rst) mon_q[g] <= 1'b0;
        else     mon_q[g] <= flat[sel[g]];
      end
    end
  endgenerate
endmodule

// File: rtl/mon_out_sel.sv
module mon_out_sel
  import mon_sel_pkg::*;
#(
  parameter int DIV_RATIO = 10,
  parameter int NUM_OUT   = 4,
  parameter int ADDR_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [SEL_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [SEL_W-1:0]    rd_data,
  input  logic [NUM_MULT-1:0] mult_in,
  input  logic [NUM_EXT-1:0]  ext_in,
  input  logic [NUM_DBG-1:0]  dbg_in,
  input  logic [NUM_AND-1:0]  and_in,
  input  logic [NUM_UNIT-1:0] unit_in,
  input  logic [NUM_OR-1:0]   or_in,
  output logic [NUM_OUT-1:0]  mon_out,
  output logic                ts_clk,
  output logic                acq_stopped
);
  localparam int INHIBIT_BIT = NUM_EXT - 1;

  logic [NUM_OUT-1:0][SEL_W-1:0] sel_q;
  logic [TS_W-1:0]               ts_sel_q;
  logic [NUM_REF-1:0]            ref_clk;
  logic                          ts_src;
  src_bus_t                      srcs;
  logic [SRC_W-1:0]              flat;

  decade_div_chain #(.RATIO(DIV_RATIO), .NUM_STAGES(NUM_REF)) u_div (
    .clk(clk), .rst(rst), .clk_out(ref_clk)
  );

  mon_cfg_regs #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W), .TS_W(TS_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sel_q(sel_q), .ts_sel_q(ts_sel_q)
  );

  ts_clk_pick #(.NUM_REF(NUM_REF), .TS_W(TS_W)) u_ts (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .ts_sel(ts_sel_q),
    .ts_src(ts_src), .ts_clk(ts_clk)
  );

  always_comb begin
    srcs.mult_v = mult_in;
    srcs.ext_v  = ext_in;
    srcs.dbg_v  = dbg_in;
    srcs.ref_v  = ref_clk;
    srcs.ts_v   = ts_src;
    srcs.and_v  = and_in;
    srcs.unit_v = unit_in;
    srcs.or_v   = or_in;
    flat        = build_flat(srcs);
  end

  mon_mux_bank #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_mux (
    .clk(clk), .rst(rst), .flat(flat), .sel(sel_q), .mon_q(mon_out)
  );

  always_ff @(posedge clk) begin
    if (rst) acq_stopped <= 1'b0;
    else     acq_stopped <= ext_in[INHIBIT_BIT];
  end
endmodule

// File: rtl/mon_out_sel_chk.sv
module mon_out_sel_chk
  import mon_sel_pkg::*;
#(
  parameter int DIV_RATIO = 10,
  parameter int NUM_OUT   = 4,
  parameter int ADDR_W    = 3
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          wr_en,
  input logic [ADDR_W-1:0]             wr_addr,
  input logic [SEL_W-1:0]              wr_data,
  input logic [NUM_EXT-1:0]            ext_in,
  input logic [NUM_OUT-1:0]            mon_out,
  input logic                          ts_clk,
  input logic                          acq_stopped,
  input logic [NUM_OUT-1:0][SEL_W-1:0] sel_q,
  input logic [TS_W-1:0]               ts_sel_q,
  input logic                          ref0
);
  localparam int HALF  = DIV_RATIO / 2;
  localparam int RUN_W = $clog2(HALF + 1);

  logic [RUN_W-1:0] run_cnt;
  always_ff @(posedge clk) begin
    if (rst)                            run_cnt <= '0;
    else if (run_cnt == RUN_W'(HALF-1)) run_cnt <= '0;
    else                                run_cnt <= run_cnt + 1'b1;
  end

  // R9
  acq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> acq_stopped == $past(ext_in[NUM_EXT-1]));

  // R5
  ts_fallback_chk: assert property (@(posedge clk) disable iff (rst)
    (ts_sel_q > TS_W'(NUM_REF-1)) |=> ts_clk == $past(ref0));

  // R10
  ts_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(NUM_OUT)) |=> ts_sel_q == $past(wr_data[TS_W-1:0]));

  // R3
  ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_cnt != RUN_W'(HALF-1)) |=> $stable(ref0));

  // R3
  ref_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (run_cnt == RUN_W'(HALF-1)) |=> !$stable(ref0));

  genvar g;
  generate
    for (g = 0; g < NUM_OUT; g++) begin : g_chk
      // R7
      reserved_low_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_q[g] inside {6'd38, 6'd39, 6'd42, 6'd43, 6'd44, 6'd45, 6'd46, 6'd47})
        |=> !mon_out[g]);

      // R2
      ext_route_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_q[g] == SEL_W'(CODE_EXT + (g % NUM_EXT)))
        |=> mon_out[g] == $past(ext_in[g % NUM_EXT]));

      // R10
      sel_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(g)) |=> sel_q[g] == $past(wr_data));
    end
  endgenerate
endmodule

bind mon_out_sel mon_out_sel_chk #(
  .DIV_RATIO(DIV_RATIO), .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .ext_in(ext_in), .mon_out(mon_out), .ts_clk(ts_clk), .acq_stopped(acq_stopped),
  .sel_q(sel_q), .ts_sel_q(ts_sel_q), .ref0(ref_clk[0])
);

// File: tb/mon_out_sel_tb.sv
module mon_out_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int R          = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [5:0]  wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [5:0]  rd_data;
  logic [23:0] mult_in = '0;
  logic [3:0]  ext_in = '0;
  logic [3:0]  dbg_in = '0;
  logic [1:0]  and_in = '0;
  logic [7:0]  unit_in = '0;
  logic [7:0]  or_in = '0;
  logic [3:0]  mon_out;
  logic        ts_clk;
  logic        acq_stopped;

  int checks = 0;
  int fails  = 0;
  int n      = 0;
  int ts_m   = 0;
  int code_m [4];
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) n <= 0;
    else     n <= n + 1;
  end

  mon_out_sel #(.DIV_RATIO(R)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .mult_in(mult_in), .ext_in(ext_in),
    .dbg_in(dbg_in), .and_in(and_in), .unit_in(unit_in), .or_in(or_in),
    .mon_out(mon_out), .ts_clk(ts_clk), .acq_stopped(acq_stopped)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, n);
    end
  endtask

  function automatic bit ref_m(input int k, input int s);
    int p;
    p = 1;
    for (int i = 0; i < k; i++) p = p * R;
    return ((s / p) % R) >= (R / 2);
  endfunction

  function automatic bit ts_exp(input int s);
    return (ts_m <= 4) ? ref_m(ts_m, s) : ref_m(0, s);
  endfunction

  function automatic bit exp_src(input int code, input int s);
    if (code < 24) return mult_in[code];
    if (code < 28) return ext_in[code-24];
    if (code < 32) return dbg_in[code-28];
    if (code < 37) return ref_m(code-32, s);
    if (code == 37) return ts_exp(s);
    if (code == 40 || code == 41) return and_in[code-40];
    if (code >= 48 && code < 56) return unit_in[code-48];
    if (code >= 56) return or_in[code-56];
    return 1'b0;
  endfunction

  function automatic string req_of(input int code);
    if (code < 24) return "R1";
    if (code < 32) return "R2";
    if (code < 37) return "R3";
    if (code == 37) return "R4";
    if (code == 40 || code == 41 || code >= 48) return "R6";
    return "R7";
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 6'(d);
    if (a < 4) code_m[a] = d;
    if (a == 4) ts_m = d % 8;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input int a, input int exp);
    @(negedge clk);
    rd_addr = 3'(a);
    @(negedge clk);
    check(req, int'(rd_data), exp);
  endtask

  task automatic set_pattern(input bit inv);
    mult_in = inv ? ~24'hA5C31E : 24'hA5C31E;
    ext_in  = inv ? ~4'b1010 : 4'b1010;
    dbg_in  = inv ? ~4'b0110 : 4'b0110;
    and_in  = inv ? ~2'b10 : 2'b10;
    unit_in = inv ? ~8'hC5 : 8'hC5;
    or_in   = inv ? ~8'h3A : 8'h3A;
  endtask

  task automatic check_outs(input string tag_r8);
    for (int o = 0; o < 4; o++) begin
      check(req_of(code_m[o]), int'(mon_out[o]), int'(exp_src(code_m[o], n-1)));
    end
    check(tag_r8, int'(ts_clk), int'(ts_exp(n-1)));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) code_m[i] = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", int'(mon_out), 0);
    check("R11", int'(ts_clk), 0);
    check("R11", int'(acq_stopped), 0);
    check("R11", int'(rd_data), 0);
    rst = 1'b0;
    for (int a = 0; a < 8; a++) rd_check("R11", a, 0);

    // R10 readback, ts field width, ignored addresses
    wr(0, 6'h15); wr(1, 6'h2A); wr(2, 6'h3F); wr(3, 6'h07); wr(4, 6'h3D);
    rd_check("R10", 0, 6'h15);
    rd_check("R10", 1, 6'h2A);
    rd_check("R10", 2, 6'h3F);
    rd_check("R10", 3, 6'h07);
    rd_check("R10", 4, 5);
    wr(5, 6'h11); wr(6, 6'h22); wr(7, 6'h33);
    for (int a = 5; a < 8; a++) rd_check("R10", a, 0);
    rd_check("R10", 0, 6'h15);
    rd_check("R10", 3, 6'h07);
    rd_check("R10", 4, 5);
    wr(4, 0);

    // R9 run-inhibit status
    @(negedge clk); ext_in = 4'b1000;
    @(negedge clk); check("R9", int'(acq_stopped), 1);
    ext_in = 4'b0000;
    @(negedge clk); check("R9", int'(acq_stopped), 0);

    // R1 R2 R6 R7 R8: full code sweep, distinct code on each output
    for (int c = 0; c < 64; c++) begin
      for (int o = 0; o < 4; o++) wr(o, (c + 13*o) % 64);
      for (int p = 0; p < 2; p++) begin
        @(negedge clk); set_pattern(p[0]);
        @(negedge clk); check_outs("R8");
      end
    end

    // R3 reference clocks observed continuously
    wr(0, 32); wr(1, 33); wr(2, 34); wr(3, 36);
    @(negedge clk);
    for (int t = 0; t < 2200; t++) begin
      @(negedge clk); check_outs("R4");
    end

    // R4 R5 timestamp select sweep incl. fallback values
    for (int v = 0; v < 8; v++) begin
      wr(4, v); wr(0, 37);
      @(negedge clk);
      for (int t = 0; t < 1100; t++) begin
        @(negedge clk);
        check(v > 4 ? "R5" : "R4", int'(mon_out[0]), int'(ts_exp(n-1)));
        check(v > 4 ? "R5" : "R4", int'(ts_clk), int'(ts_exp(n-1)));
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule